// File: doc/BRIEF.md
# Serial Transmitter with In-Word Parity

This block turns parallel words into asynchronous serial frames on a single line. A frame has a low start bit, then a word of eight or nine bits sent least significant bit first, then a high stop bit. Each bit lasts a fixed number of baud-tick periods. The line rests high between frames. When parity is turned on, it does not add a bit to the frame. The parity bit takes the place of the word's most significant bit, so an 8-bit word carries seven data bits and a 9-bit word carries eight.

A writer waits for `tx_empty`, then pulses `wr_en` with the word on `wr_data`. The word waits in a single holding register until the shifter is free. A frame starts on a baud tick. At that moment the holding register is copied into the shifter and the word length and parity settings are captured. Changes to the configuration inputs during a frame therefore affect only later frames. A word written during a frame is sent right after that frame's stop bit, with no idle gap.

Top module: `sertx_core`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1 and `tx_empty` is 1.
- R2: A frame is one start bit at 0, then the word bits least significant bit first, then one stop bit at 1. Every bit lasts TICKS_PER_BIT (16) `baud_tick` pulses, and a frame begins only on a `baud_tick`.
- R3: With `cfg_nine`=0 the word has 8 bits (wr_data[7:0]). With `cfg_nine`=1 it has 9 bits (wr_data[8:0]).
- R4: With `cfg_par_en`=1, the word bit at index 7 (8-bit word) or index 8 (9-bit word) is replaced by the parity bit. The written data bit at that index is never sent. Parity covers only the bits below that index.
- R5: With `cfg_par_odd`=1, the parity bit makes the number of ones across the data bits and the parity bit odd. With `cfg_par_odd`=0, it makes that number even.
- R6: `tx_empty` goes to 0 on the clock after an accepted write. It returns to 1 on the clock edge at which that word's frame starts.
- R7: A `wr_en` pulse while `tx_empty` is 0 has no effect.
- R8: The word length and parity settings are captured when a frame starts. Changing them during a frame does not alter that frame.
- R9: If a word is held when a stop bit ends, its start bit begins at once. The next falling edge of `txd` comes exactly (word length + 2) × TICKS_PER_BIT ticks after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | 9 | Word to send (bit 8 used only for 9-bit words) |
| tx_empty | output | 1 | Holding register can accept a word |
| cfg_nine | input | 1 | 0: 8-bit word, 1: 9-bit word |
| cfg_par_en | input | 1 | 1: word MSB carries parity |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| baud_tick | input | 1 | One-cycle pulse, TICKS_PER_BIT per bit time |
| txd | output | 1 | Serial output, idles high |

## Verification
The hardest case to reach is a frame that has already started while the holding register is full, the configuration is changing, and a third write arrives. All of these must line up before the first data bit goes out. The stimulus finds the falling edge of the start bit. Within the first half of the start bit it changes the configuration, writes a second word, and writes a third word while `tx_empty` is low. It then checks the first frame's old format, the second frame's back-to-back timing and new format, and that nothing follows.

// File: rtl/sertx_core.sv
module sertx_core #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [8:0] wr_data,
  output logic       tx_empty,
  input  logic       cfg_nine,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       baud_tick,
  output logic       txd
);
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TICKS_PER_BIT - 1);

  logic [8:0]    hold_data;
  logic          hold_full;
  logic          busy;
  logic [3:0]    idx;
  logic [TW-1:0] tcnt;
  logic [8:0]    word_q;
  logic          nine_q;
  logic [3:0]    stop_idx;
  logic          bit_end, frame_end, start_go;
  logic [8:0]    dmask, new_word;
  logic          par_bit;

  assign tx_empty  = !hold_full;
  assign stop_idx  = nine_q ? 4'd10 : 4'd9;
  assign bit_end   = busy && baud_tick && (tcnt == TLAST);
  assign frame_end = bit_end && (idx == stop_idx);
  assign start_go  = baud_tick && hold_full && (!busy || frame_end);

  always_comb begin
    case ({cfg_nine, cfg_par_en})
      2'b00:   dmask = 9'h0FF;
      2'b01:   dmask = 9'h07F;
      2'b10:   dmask = 9'h1FF;
      default: dmask = 9'h0FF;
    endcase
    par_bit  = (^(hold_data & dmask)) ^ cfg_par_odd;
    new_word = hold_data & dmask;
    if (cfg_par_en) begin
      if (cfg_nine) new_word[8] = par_bit;
      else          new_word[7] = par_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (start_go) begin
      hold_full <= 1'b0;
    end else if (wr_en && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      tcnt   <= '0;
      word_q <= '0;
      nine_q <= 1'b0;
    end else if (start_go) begin
      busy   <= 1'b1;
      idx    <= '0;
      tcnt   <= '0;
      word_q <= new_word;
      nine_q <= cfg_nine;
    end else if (bit_end) begin
      tcnt <= '0;
      if (frame_end) busy <= 1'b0;
      else begin
        idx <= idx + 4'd1;
        if (idx != 4'd0) word_q <= word_q >> 1;
      end
    end else if (busy && baud_tick) begin
      tcnt <= tcnt + TW'(1);
    end
  end

  always_comb begin
    if (!busy)                txd = 1'b1;
    else if (idx == 4'd0)     txd = 1'b0;
    else if (idx == stop_idx) txd = 1'b1;
    else                      txd = word_q[0];
  end

  assert_start_on_held_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hold_full));
  assert_start_edge_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(baud_tick));
  assert_cfg_held_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_go) |=> $stable(nine_q));
  assert_full_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold_full) |=> $stable(hold_data));
  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_index_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= stop_idx));
endmodule

// File: tb/sertx_core_test.sv
module sertx_core_test;
  logic clk = 0, rst_n = 0, wr_en = 0, cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0;
  logic baud_tick = 0;
  logic [8:0] wr_data = '0;
  logic tx_empty, txd;
  int cyc = 0, checks = 0, errors = 0;
  logic [1:0] tdiv = '0;

  sertx_core uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tx_empty(tx_empty), .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .baud_tick(baud_tick), .txd(txd));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tdiv <= tdiv + 2'd1;
    baud_tick <= (tdiv == 2'd3);
  end

  always @(negedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // {nine, par_en, odd, data, expected word}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 9'h0A5, 9'h0A5},
    {1'b1, 1'b0, 1'b0, 9'h1C3, 9'h1C3},
    {1'b0, 1'b1, 1'b0, 9'h187, 9'h087},
    {1'b0, 1'b1, 1'b1, 9'h187, 9'h007},
    {1'b1, 1'b1, 1'b0, 9'h155, 9'h055},
    {1'b1, 1'b1, 1'b1, 9'h055, 9'h155},
    {1'b0, 1'b1, 1'b1, 9'h000, 9'h080},
    {1'b1, 1'b1, 1'b0, 9'h1FF, 9'h0FF}
  };

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic write(input logic [8:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_start(output int t0);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
  endtask

  task automatic read_rest(input int t0, input int w, output logic [8:0] word,
                           output logic st, output logic sp);
    word = '0;
    while (cyc < t0 + 32) @(negedge clk);
    st = txd;
    for (int b = 0; b < w; b++) begin
      while (cyc < t0 + 32 + 64 * (b + 1)) @(negedge clk);
      word[b] = txd;
    end
    while (cyc < t0 + 32 + 64 * (w + 1)) @(negedge clk);
    sp = txd;
  endtask

  initial begin
    int t0, t1, w;
    logic [8:0] word, expw;
    logic st, sp, quiet;
    repeat (4) @(negedge clk);
    chk(txd === 1'b1, "R1 reset txd", txd, 1);
    chk(tx_empty === 1'b1, "R1 reset tx_empty", tx_empty, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      cfg_nine = VEC[i][20]; cfg_par_en = VEC[i][19]; cfg_par_odd = VEC[i][18];
      expw = VEC[i][8:0];
      w = cfg_nine ? 9 : 8;
      write(VEC[i][17:9]);
      wait_start(t0);
      read_rest(t0, w, word, st, sp);
      chk(st === 1'b0, "R2 start bit", st, 0);
      chk(word == expw, "R3 R4 R5 word bits", word, expw);
      chk(sp === 1'b1, "R2 stop bit", sp, 1);
      repeat (80) @(negedge clk);
    end

    cfg_nine = 0; cfg_par_en = 0; cfg_par_odd = 0;
    @(negedge clk); wr_en = 1; wr_data = 9'h03C;
    @(negedge clk); wr_en = 0;
    chk(tx_empty === 1'b0, "R6 empty low after write", tx_empty, 0);
    wait_start(t0);
    chk(tx_empty === 1'b1, "R6 empty high at frame start", tx_empty, 1);
    cfg_nine = 1; cfg_par_en = 1; cfg_par_odd = 1;
    write(9'h0F0);
    chk(tx_empty === 1'b0, "R6 empty low while queued", tx_empty, 0);
    write(9'h111);
    read_rest(t0, 8, word, st, sp);
    chk(word == 9'h03C, "R8 frame keeps old config", word, 9'h03C);
    chk(sp === 1'b1, "R8 stop at old position", sp, 1);
    wait_start(t1);
    chk(t1 - t0 == 640, "R9 back-to-back start", t1 - t0, 640);
    read_rest(t1, 9, word, st, sp);
    chk(word == 9'h1F0, "R8 R7 queued word with new config", word, 9'h1F0);
    chk(sp === 1'b1, "R2 stop of queued frame", sp, 1);
    quiet = 1;
    for (int k = 0; k < 1400; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) quiet = 0;
    end
    chk(quiet == 1'b1, "R7 ignored write sends nothing", quiet, 1);
    chk(tx_empty === 1'b1, "R1 idle tx_empty", tx_empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule